// File: doc/BRIEF.md
# Serial Delay-Select Configuration Register

This block holds the delay settings for one I/O pin. It is loaded over a serial configuration bus that many pins share. The serial data bit, the configuration clock and the update strobe go to every instance. Each instance also has its own enable. While its enable is high, an instance moves one bit per configuration clock edge into an 11-bit staging register. Instances whose enable is low keep their staged contents.

A single update strobe serves all instances. On each clock edge where the strobe is high, every instance copies its staged value into stable output registers. Those registers drive three delay selects: a 4-bit input delay, a 3-bit select for the first output delay chain and a 4-bit select for the second output delay chain. The position of each bit in the stream decides which field it lands in. Within a field, the bit that arrived first becomes the most significant bit.

The reset is synchronous and active high. It clears both the staging register and the outputs to zero, which is the minimum delay.

Top module: `dly_cfg_reg`

## Requirements
- R1: While `rst` is high at a clock edge, the staging register and all three outputs are cleared to zero. An update that follows a reset, with no shifting in between, therefore drives zeros.
- R2: On an edge where `cfg_en` is low, the staging register keeps its contents. A later update then applies the value that was staged before that edge.
- R3: After 11 enabled edges, the first four bits shifted in form `in_dly`, with the earliest bit in bit 3.
- R4: Bits five to seven of the stream form `out_dly_a`, with the earliest of them in bit 2.
- R5: The last four bits of the stream form `out_dly_b`, with the earliest of them in bit 3 and the final bit in bit 0.
- R6: The outputs change only on an edge where `cfg_upd` is high. They hold their value while bits are shifting.
- R7: An update edge copies the staged value as it stood before that edge. This holds even if the same edge also shifts in a new bit.
- R8: Staging always keeps the 11 most recent enabled bits. With more than 11 shifts, the oldest bits drop out. With fewer, earlier staged bits move toward the most significant end.
- R9: The update strobe acts whether or not `cfg_en` is high, so a disabled instance applies its unchanged staged value again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared configuration clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_din | input | 1 | Shared serial configuration bit |
| cfg_en | input | 1 | Per-instance shift enable |
| cfg_upd | input | 1 | Shared update strobe |
| in_dly | output | 4 | Input delay select |
| out_dly_a | output | 3 | First output delay chain select |
| out_dly_b | output | 4 | Second output delay chain select |

## Verification
The hardest case to reach from the ports is an update on the same edge as a shift. Here the applied value must be the one staged before that edge, not the one that includes the new bit. The bench first loads a known pattern, then drives enable, data and update together on one edge. A second update then shows that the new bit was still staged. Every one of the 2048 stream values is swept through one instance. A second instance on the same bus stays disabled and must re-apply its own staged value at every update. Short and long loads confirm that only the most recent eleven bits count.

// File: rtl/dly_cfg_pkg.sv
package dly_cfg_pkg;

    localparam int IN_W  = 4;
    localparam int OA_W  = 3;
    localparam int OB_W  = 4;
    localparam int CFG_W = IN_W + OA_W + OB_W;

    typedef struct packed {
        logic [IN_W-1:0] in_sel;
        logic [OA_W-1:0] out_a_sel;
        logic [OB_W-1:0] out_b_sel;
    } dly_sel_t;

    // Earliest-shifted bits sit at the top of the staging word.
    function automatic dly_sel_t split_stream(input logic [CFG_W-1:0] s);
        dly_sel_t r;
        r.in_sel    = s[CFG_W-1 -: IN_W];
        r.out_a_sel = s[OA_W+OB_W-1 -: OA_W];
        r.out_b_sel = s[OB_W-1:0];
        return r;
    endfunction

endpackage

// File: rtl/dly_cfg_shift.sv
module dly_cfg_shift #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         din,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (en) begin
            q <= {q[W-2:0], din};
        end
    end

endmodule

// File: rtl/dly_cfg_hold.sv
module dly_cfg_hold
    import dly_cfg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  dly_sel_t d,
    output dly_sel_t q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end

endmodule

// File: rtl/dly_cfg_reg.sv
module dly_cfg_reg
    import dly_cfg_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_din,
    input  logic            cfg_en,
    input  logic            cfg_upd,
    output logic [IN_W-1:0] in_dly,
    output logic [OA_W-1:0] out_dly_a,
    output logic [OB_W-1:0] out_dly_b
);

    logic [CFG_W-1:0] stage_q;
    dly_sel_t         stage_sel;
    dly_sel_t         applied;

    dly_cfg_shift #(.W(CFG_W)) u_shift (
        .clk (clk),
        .rst (rst),
        .en  (cfg_en),
        .din (cfg_din),
        .q   (stage_q)
    );

    assign stage_sel = split_stream(stage_q);

    dly_cfg_hold u_hold (
        .clk  (clk),
        .rst  (rst),
        .load (cfg_upd),
        .d    (stage_sel),
        .q    (applied)
    );

    assign in_dly    = applied.in_sel;
    assign out_dly_a = applied.out_a_sel;
    assign out_dly_b = applied.out_b_sel;

endmodule

// File: rtl/dly_cfg_reg_chk.sv
module dly_cfg_reg_chk
    import dly_cfg_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             cfg_din,
    input logic             cfg_en,
    input logic             cfg_upd,
    input logic [CFG_W-1:0] stage,
    input logic [CFG_W-1:0] applied
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (stage == '0) && (applied == '0));

    // R6
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_upd |=> $stable(applied));

    // R7
    upd_copy_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_upd |=> applied == $past(stage));

    // R2
    stage_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_en |=> $stable(stage));

    // R8
    shift_in_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_en |=> (stage[0] == $past(cfg_din)) &&
                   (stage[CFG_W-1:1] == $past(stage[CFG_W-2:0])));

endmodule

bind dly_cfg_reg dly_cfg_reg_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .cfg_din (cfg_din),
    .cfg_en  (cfg_en),
    .cfg_upd (cfg_upd),
    .stage   (stage_q),
    .applied ({in_dly, out_dly_a, out_dly_b})
);

// File: tb/dly_cfg_reg_tb.sv
`timescale 1ns/1ps
module dly_cfg_reg_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic din = 1'b0;
    logic en_a = 1'b0;
    logic en_b = 1'b0;
    logic upd = 1'b0;
    logic [3:0] a_in, b_in;
    logic [2:0] a_oa, b_oa;
    logic [3:0] a_ob, b_ob;
    int checks = 0;
    int errors = 0;
    logic [10:0] b_val;

    always #2.5 clk = ~clk;

    dly_cfg_reg u_dut (
        .clk(clk), .rst(rst), .cfg_din(din), .cfg_en(en_a), .cfg_upd(upd),
        .in_dly(a_in), .out_dly_a(a_oa), .out_dly_b(a_ob)
    );

    dly_cfg_reg u_dut_b (
        .clk(clk), .rst(rst), .cfg_din(din), .cfg_en(en_b), .cfg_upd(upd),
        .in_dly(b_in), .out_dly_a(b_oa), .out_dly_b(b_ob)
    );

    task automatic check_a(input string req, input logic [10:0] exp);
        logic [10:0] got;
        got = {a_in, a_oa, a_ob};
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s inst A: got in=%0d a=%0d b=%0d expected in=%0d a=%0d b=%0d",
                     req, got[10:7], got[6:4], got[3:0], exp >> 7, (exp >> 4) & 7, exp & 15);
        end
    endtask

    task automatic check_b(input string req, input logic [10:0] exp);
        logic [10:0] got;
        got = {b_in, b_oa, b_ob};
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s inst B: got %h expected %h", req, got, exp);
        end
    endtask

    // one edge: drive at negedge, edge happens, return at next negedge
    task automatic step(input logic ea, input logic eb, input logic d, input logic u);
        en_a = ea; en_b = eb; din = d; upd = u;
        @(negedge clk);
        en_a = 1'b0; en_b = 1'b0; upd = 1'b0;
    endtask

    task automatic load(input logic ea, input logic eb, input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) step(ea, eb, v[i], 1'b0);
    endtask

    initial begin
        logic [10:0] prev;
        logic [10:0] exp;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check_a("R1", 11'h000);
        check_b("R1", 11'h000);

        // load B once and apply
        b_val = 11'h5A3;
        load(1'b0, 1'b1, {21'd0, b_val}, 11);
        step(1'b0, 1'b0, 1'b0, 1'b1);
        check_b("R3", b_val);
        check_a("R9", 11'h000);

        prev = 11'h000;
        for (int v = 0; v < 2048; v++) begin
            load(1'b1, 1'b0, v, 11);
            // R6 outputs untouched by shifting
            check_a("R6", prev);
            step(1'b0, 1'b0, 1'b0, 1'b1);
            exp = 11'(v);
            check_a("R3", {4'(v >> 7), 3'((v >> 4) & 7), 4'(v & 15)});
            check_a("R4_R5", exp);
            // R2 and R9: B disabled, re-applies its own staged value
            check_b("R2", b_val);
            prev = exp;
        end

        // R8 long load: 15 bits, last 11 apply
        load(1'b1, 1'b0, 32'h4ABC, 15);
        step(1'b0, 1'b0, 1'b0, 1'b1);
        check_a("R8", 11'(32'h4ABC & 32'h7FF));
        // R8 short load: 3 more bits
        load(1'b1, 1'b0, 32'h5, 3);
        step(1'b0, 1'b0, 1'b0, 1'b1);
        check_a("R8", 11'(((32'h4ABC << 3) | 32'h5) & 32'h7FF));

        // R7 update on same edge as shift
        load(1'b1, 1'b0, 32'h2C9, 11);
        step(1'b1, 1'b0, 1'b1, 1'b1);
        check_a("R7", 11'h2C9);
        step(1'b0, 1'b0, 1'b0, 1'b1);
        check_a("R7", 11'(((32'h2C9 << 1) | 1) & 32'h7FF));

        // R6 hold while idle, no update
        step(1'b1, 1'b1, 1'b0, 1'b0);
        check_a("R6", 11'(((32'h2C9 << 1) | 1) & 32'h7FF));

        // R1 reset mid-load clears staging too
        load(1'b1, 1'b1, 32'h3F, 6);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check_a("R1", 11'h000);
        check_b("R1", 11'h000);
        step(1'b0, 1'b0, 1'b0, 1'b1);
        check_a("R1", 11'h000);
        check_b("R1", 11'h000);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1000000;
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule